// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide flash device. It watches a synchronous host bus, where a write is a one-cycle write strobe with an address and a data byte and a read is a one-cycle read strobe with an address. It turns one-write and two-write command sequences into a read mode and into job requests for an array-operation engine outside the block. The engine is told to start with a one-cycle start pulse. It reports the end of the job with a one-cycle done pulse.

The sequencer has four read modes. In array mode it returns the array byte. In identifier mode it returns fixed codes. In erase-verify mode it returns the byte at an address captured earlier. While a job runs it returns a status byte. The status byte carries a data-polling bit and a bit that alternates on every read. The high-voltage-present input gates everything. Without it the block stays in array mode and ignores writes.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `hv_ok` is low, writes are ignored: no job starts and the mode is forced to array read from the next clock. Reads then return `arr_rdata`.
- R2: Writing 00H selects array read. Reads return the byte on `arr_rdata` for the read address, and the mode stays until another command is accepted. Any byte that is not a known command, written in a read mode, also selects array read.
- R3: Writing 90H selects identifier mode. A read at address 0 returns C2H, a read at address 1 returns 1AH, and a read at any other address returns 00H.
- R4: Writing 40H arms programming. The next write, unless its data is FFH, pulses `job_start` for one cycle with `job_kind` = 1, `job_addr` = that write's address and `job_data` = that write's data.
- R5: Writing 30H then 30H starts a job with `job_kind` = 2 (automatic chip erase). Writing 20H then 20H starts a job with `job_kind` = 3 (plain chip erase).
- R6: After any set-up command (40H, 30H or 20H), two writes of FFH abort the sequence. No job starts and the mode returns to array read.
- R7: After the 30H or 20H set-up, a second write that neither matches the set-up nor is FFH returns to array read with no job.
- R8: While a job runs, a read returns a status byte with bits 5..0 at 0. Bit 7 is the inverse of `job_data` bit 7 for a program job and 0 for an erase job.
- R9: While a job runs, bit 6 of the status byte is 0 on the first read after the job starts and inverts on each following read. Once the job ends, reads return array data again.
- R10: While a job runs, writes are ignored and start nothing. A `job_done` pulse returns the mode to array read.
- R11: Writing A0H selects erase-verify. The write's address is captured and `arr_addr` stays at it with `verify_en` high. Reads return `arr_rdata` for that address whatever the read address.
- R12: `rdata` is registered. It changes only on the clock edge that samples `rd_stb`, which makes it valid one cycle after the read strobe, and it holds between reads. After reset it is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hv_ok | input | 1 | High-voltage-present flag; low means read-only |
| addr | input | 17 | Bus address for writes and reads |
| wdata | input | 8 | Write data / command byte |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| rdata | output | 8 | Registered read data |
| arr_addr | output | 17 | Address presented to the array |
| arr_rdata | input | 8 | Array byte at `arr_addr` |
| verify_en | output | 1 | High in erase-verify mode |
| job_start | output | 1 | One-cycle job launch pulse |
| job_kind | output | 2 | 1 program, 2 automatic chip erase, 3 chip erase |
| job_addr | output | 17 | Captured program address |
| job_data | output | 8 | Captured program data |
| job_done | input | 1 | One-cycle job completion pulse |

## Verification
Random command streams mix every opcode with arbitrary bytes, so a matching confirm, a mismatching second write, a double FFH and a stray byte can each follow every set-up. This shows whether jobs start only on an exact pair. Reads are spread over addresses 0, 1 and random locations in every mode, which separates the identifier, verify and array paths. Each job is polled several times to check the alternating bit and both polarities of the polling bit, and a write is made during the job to show that it is ignored. Windows with the high-voltage flag low show that writes are dropped and that the mode falls back to array read.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
// Shared opcodes, state and job encodings for the flash command sequencer.
package flash_seq_pkg;
    localparam int DATA_W = 8;

    localparam logic [7:0] OP_READ       = 8'h00;
    localparam logic [7:0] OP_IDENT      = 8'h90;
    localparam logic [7:0] OP_PROG       = 8'h40;
    localparam logic [7:0] OP_AUTO_ERASE = 8'h30;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_VERIFY     = 8'hA0;
    localparam logic [7:0] OP_RESET      = 8'hFF;
    localparam logic [7:0] ID_MFR        = 8'hC2;
    localparam logic [7:0] ID_DEV        = 8'h1A;

    typedef enum logic [2:0] {
        M_ARRAY, M_IDENT, M_VERIFY, M_SET_PROG,
        M_SET_AUTO, M_SET_ERASE, M_ABORT1, M_BUSY
    } seq_state_t;

    typedef enum logic [1:0] {
        JOB_NONE = 2'd0, JOB_PROG = 2'd1, JOB_AUTO_ERASE = 2'd2, JOB_ERASE = 2'd3
    } job_kind_t;
endpackage

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
// Command decoder: walks the one- and two-write command sequences,
// launches jobs and captures the verify address.
// Assumes wr_stb is a one-cycle pulse and job_done a one-cycle pulse.
module flash_cmd_decoder
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_ok,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              job_done,
    output seq_state_t        state_q,
    output logic              job_start,
    output logic [1:0]        job_kind,
    output logic [ADDR_W-1:0] job_addr,
    output logic [DATA_W-1:0] job_data,
    output logic [ADDR_W-1:0] vaddr_q
);
    seq_state_t state_n;
    logic       start_n;
    job_kind_t  kind_n;
    logic       read_class;
    logic       verify_cap;

    assign read_class = (state_q == M_ARRAY) || (state_q == M_IDENT) || (state_q == M_VERIFY);
    assign verify_cap = hv_ok && wr_stb && read_class && (wdata == OP_VERIFY);

    // Next-state and job-launch decode.
    always_comb begin
        state_n = state_q;
        start_n = 1'b0;
        kind_n  = JOB_NONE;
        if (!hv_ok) begin
            state_n = M_ARRAY;
        end else if (state_q == M_BUSY) begin
            if (job_done) state_n = M_ARRAY;
        end else if (wr_stb) begin
            case (state_q)
                M_SET_PROG: begin
                    if (wdata == OP_RESET) state_n = M_ABORT1;
                    else begin
                        state_n = M_BUSY;
                        start_n = 1'b1;
                        kind_n  = JOB_PROG;
                    end
                end
                M_SET_AUTO: begin
                    if (wdata == OP_AUTO_ERASE) begin
                        state_n = M_BUSY;
                        start_n = 1'b1;
                        kind_n  = JOB_AUTO_ERASE;
                    end else if (wdata == OP_RESET) state_n = M_ABORT1;
                    else state_n = M_ARRAY;
                end
                M_SET_ERASE: begin
                    if (wdata == OP_ERASE) begin
                        state_n = M_BUSY;
                        start_n = 1'b1;
                        kind_n  = JOB_ERASE;
                    end else if (wdata == OP_RESET) state_n = M_ABORT1;
                    else state_n = M_ARRAY;
                end
                M_ABORT1: state_n = M_ARRAY;
                default: begin
                    case (wdata)
                        OP_IDENT:      state_n = M_IDENT;
                        OP_PROG:       state_n = M_SET_PROG;
                        OP_AUTO_ERASE: state_n = M_SET_AUTO;
                        OP_ERASE:      state_n = M_SET_ERASE;
                        OP_VERIFY:     state_n = M_VERIFY;
                        default:       state_n = M_ARRAY;
                    endcase
                end
            endcase
        end
    end

    // State register and one-cycle start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= M_ARRAY;
            job_start <= 1'b0;
        end else begin
            state_q   <= state_n;
            job_start <= start_n;
        end
    end

    // Job parameter capture on the confirming write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_kind <= 2'(JOB_NONE);
            job_addr <= '0;
            job_data <= '0;
        end else if (start_n) begin
            job_kind <= 2'(kind_n);
            job_addr <= addr;
            job_data <= wdata;
        end
    end

    // Erase-verify address capture.
    always_ff @(posedge clk) begin
        if (!rst_n)          vaddr_q <= '0;
        else if (verify_cap) vaddr_q <= addr;
    end

    p_hv_low_array_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_ok |=> state_q == M_ARRAY)
        else $error("R1: mode not array after hv low");

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start)
        else $error("R4: start pulse longer than one cycle");

    p_start_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> $past(wr_stb && hv_ok))
        else $error("R5: job started without an accepted write");
endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
// Status byte generator for running jobs: polling bit on bit 7,
// alternating bit on bit 6, zeros below.
// Assumes busy is high for the whole job and rd_stb is a one-cycle pulse.
module flash_status_gen
    import flash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_stb,
    input  logic [1:0]        job_kind,
    input  logic              job_d7,
    output logic [DATA_W-1:0] status
);
    logic toggle_q;
    logic poll_bit;

    // Alternating bit: parked at 0 when idle, inverted per read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) toggle_q <= 1'b0;
        else if (rd_stb)     toggle_q <= ~toggle_q;
    end

    // Polling bit: inverse data bit for programs, 0 for erases.
    always_comb begin
        poll_bit = (job_kind == 2'(JOB_PROG)) ? ~job_d7 : 1'b0;
        status   = {poll_bit, toggle_q, {(DATA_W-2){1'b0}}};
    end
endmodule

// File: rtl/flash_read_path.sv
`timescale 1ns/1ps
// Read data selector and output register.
// Assumes arr_rdata already reflects the address the top presents.
module flash_read_path
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  seq_state_t        state_q,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel;

    // Source selection by read mode.
    always_comb begin
        case (state_q)
            M_IDENT: begin
                if (addr == ADDR_W'(0))      sel = ID_MFR;
                else if (addr == ADDR_W'(1)) sel = ID_DEV;
                else                         sel = '0;
            end
            M_BUSY:  sel = status;
            default: sel = arr_rdata;
        endcase
    end

    // Output register, loaded only by a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= sel;
    end

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rdata))
        else $error("R12: rdata moved without a read");
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
// Top of the flash command sequencer: decoder, status generator and
// read path, plus the array address steering for erase-verify.
// Assumes a synchronous host bus with one-cycle strobes.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_rdata,
    output logic              verify_en,
    output logic              job_start,
    output logic [1:0]        job_kind,
    output logic [ADDR_W-1:0] job_addr,
    output logic [7:0]        job_data,
    input  logic              job_done
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic [DATA_W-1:0] status;
    logic              busy;

    assign busy = (state_q == M_BUSY);

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .job_done(job_done),
        .state_q(state_q), .job_start(job_start), .job_kind(job_kind),
        .job_addr(job_addr), .job_data(job_data), .vaddr_q(vaddr_q)
    );

    flash_status_gen u_stat (
        .clk(clk), .rst_n(rst_n), .busy(busy), .rd_stb(rd_stb),
        .job_kind(job_kind), .job_d7(job_data[DATA_W-1]), .status(status)
    );

    flash_read_path #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .state_q(state_q),
        .addr(addr), .arr_rdata(arr_rdata), .status(status), .rdata(rdata)
    );

    // Array address steering: verify holds the captured byte address.
    always_comb begin
        verify_en = (state_q == M_VERIFY);
        arr_addr  = verify_en ? vaddr_q : addr;
    end

    p_busy_ignores_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hv_ok && !job_done) |=> busy)
        else $error("R10: left busy without done");

    p_start_enters_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> busy)
        else $error("R4: start pulse outside busy");

    p_verify_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_en && !wr_stb && hv_ok) |=> (verify_en && $stable(arr_addr)))
        else $error("R11: verify address moved");

    p_status_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_stb) |=> rdata[5:0] == 6'd0)
        else $error("R8: status low bits not zero");
endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
    localparam int AW  = 17;
    localparam int LAT = 20;
    localparam int S_ARRAY = 0, S_IDENT = 1, S_VERIFY = 2, S_SPROG = 3,
                   S_SAUTO = 4, S_SERASE = 5, S_ABORT = 6, S_BUSY = 7;

    logic          clk = 0, rst_n = 0, hv_ok = 1, wr_stb = 0, rd_stb = 0, job_done = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata, arr_rdata, job_data;
    logic [AW-1:0] arr_addr, job_addr;
    logic          verify_en, job_start;
    logic [1:0]    job_kind;

    flash_cmd_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .rdata(rdata), .arr_addr(arr_addr),
        .arr_rdata(arr_rdata), .verify_en(verify_en), .job_start(job_start),
        .job_kind(job_kind), .job_addr(job_addr), .job_data(job_data),
        .job_done(job_done)
    );

    always #10 clk = ~clk;

    // Array-operation stub with a small array.
    logic [7:0] mem [0:255];
    int         cnt = 0;
    logic [1:0] s_kind;
    logic [7:0] s_idx, s_data;
    assign arr_rdata = mem[arr_addr[7:0]];
    always @(posedge clk) begin
        job_done <= 1'b0;
        if (job_start) begin
            cnt <= LAT; s_kind <= job_kind; s_idx <= job_addr[7:0]; s_data <= job_data;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                job_done <= 1'b1;
                if (s_kind == 2'd1) mem[s_idx] <= mem[s_idx] & s_data;
                else for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
            end
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;
    int m_st = S_ARRAY;
    int m_kind = 0;
    logic m_d7 = 0, m_tog = 0;
    logic [AW-1:0] m_vaddr = '0, m_jaddr = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] id_val(input logic [AW-1:0] a);
        if (a == 0) return 8'hC2;
        if (a == 1) return 8'h1A;
        return 8'h00;
    endfunction

    function automatic int read_next(input logic [7:0] d);
        case (d)
            8'h90: return S_IDENT;
            8'h40: return S_SPROG;
            8'h30: return S_SAUTO;
            8'h20: return S_SERASE;
            8'hA0: return S_VERIFY;
            default: return S_ARRAY;
        endcase
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_stb = 1;
        @(negedge clk); wr_stb = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        logic [7:0] exp;
        string tag;
        case (m_st)
            S_IDENT:  begin exp = id_val(a); tag = "R3"; end
            S_VERIFY: begin exp = mem[m_vaddr[7:0]]; tag = "R11"; end
            S_BUSY:   begin exp = {(m_kind == 1) ? ~m_d7 : 1'b0, m_tog, 6'd0}; tag = "R8/R9"; end
            default:  begin exp = mem[a[7:0]]; tag = hv_ok ? "R2" : "R1"; end
        endcase
        @(negedge clk); addr = a; rd_stb = 1;
        @(negedge clk); rd_stb = 0;
        chk(rdata === exp, tag, rdata, exp);
        if (m_st == S_BUSY) m_tog = ~m_tog;
    endtask

    task automatic run_job();
        for (int k = 0; k < 3; k++) rd($urandom);
        do_write($urandom, 8'h00);
        chk(job_start === 1'b0, "R10", job_start, 0);
        repeat (LAT + 3) @(negedge clk);
        m_st = S_ARRAY;
        rd(m_jaddr);
        rd(m_jaddr);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        int nk = 0;
        int ns = m_st;
        if (!hv_ok) ns = S_ARRAY;
        else case (m_st)
            S_SPROG:  if (d == 8'hFF) ns = S_ABORT; else nk = 1;
            S_SAUTO:  if (d == 8'h30) nk = 2; else if (d == 8'hFF) ns = S_ABORT; else ns = S_ARRAY;
            S_SERASE: if (d == 8'h20) nk = 3; else if (d == 8'hFF) ns = S_ABORT; else ns = S_ARRAY;
            S_ABORT:  ns = S_ARRAY;
            S_BUSY:   ns = S_BUSY;
            default:  begin ns = read_next(d); if (d == 8'hA0) m_vaddr = a; end
        endcase
        do_write(a, d);
        if (nk != 0) begin
            chk(job_start === 1'b1, (nk == 1) ? "R4" : "R5", job_start, 1);
            chk(job_kind === 2'(nk), (nk == 1) ? "R4" : "R5", job_kind, nk);
            if (nk == 1) begin
                chk(job_addr === a, "R4", job_addr, a);
                chk(job_data === d, "R4", job_data, d);
            end
            m_st = S_BUSY; m_kind = nk; m_d7 = d[7]; m_tog = 0; m_jaddr = a;
            run_job();
        end else begin
            chk(job_start === 1'b0, hv_ok ? "R6/R7" : "R1", job_start, 0);
            m_st = ns;
            if (m_st == S_VERIFY) begin
                chk(verify_en === 1'b1, "R11", verify_en, 1);
                chk(arr_addr === m_vaddr, "R11", arr_addr, m_vaddr);
            end
        end
    endtask

    function automatic logic [7:0] pick_cmd();
        case ($urandom % 9)
            0: return 8'h00; 1: return 8'h90; 2: return 8'h40;
            3: return 8'h30; 4: return 8'h20; 5: return 8'hA0;
            6: return 8'hFF; default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rdata === 8'h00, "R12", rdata, 0);
        chk(job_start === 1'b0 && verify_en === 1'b0, "R12", {job_start, verify_en}, 0);

        // Directed corner cases.
        wr(0, 8'h90); rd(0); rd(1); rd(17'h00005);
        wr(0, 8'h00); rd(17'h00012);
        wr(0, 8'h40); wr(17'h00044, 8'h5A);
        wr(0, 8'h40); wr(17'h00033, 8'hA5);
        wr(0, 8'h30); wr(0, 8'h30);
        wr(0, 8'h20); wr(0, 8'h20);
        wr(0, 8'h40); wr(0, 8'hFF); wr(0, 8'hFF); rd(0);
        wr(0, 8'h30); wr(0, 8'hFF); wr(0, 8'hFF);
        wr(0, 8'h20); wr(0, 8'h30); rd(3);
        wr(0, 8'h30); wr(0, 8'h90); rd(1);
        wr(17'h00077, 8'hA0); rd(17'h00001); rd(17'h10002);
        // R12: rdata holds between reads while the address moves.
        begin
            logic [7:0] held;
            held = rdata;
            @(negedge clk); addr = 17'h000F0;
            repeat (2) @(negedge clk);
            chk(rdata === held, "R12", rdata, held);
        end
        // R1: writes dropped while high voltage is absent.
        @(negedge clk); hv_ok = 0; @(negedge clk); m_st = S_ARRAY;
        wr(0, 8'h90); rd(0);
        wr(0, 8'h40); wr(17'h00010, 8'h00);
        rd(17'h00010);
        hv_ok = 1;

        // Constrained random command stream.
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom % 10;
            if (r < 5) wr(17'($urandom), pick_cmd());
            else if (r < 9) rd(($urandom % 3 == 0) ? 17'($urandom % 2) : 17'($urandom));
            else begin
                @(negedge clk); hv_ok = 0; @(negedge clk); m_st = S_ARRAY;
                wr(17'($urandom), pick_cmd());
                rd(17'($urandom));
                hv_ok = 1;
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule